// File: doc/BRIEF.md
# SONET Path Overhead Monitor

This block sits behind a pointer interpreter and watches the path overhead column of one STS-1 SPE or VC-3. It receives the payload one byte at a time, with a marker on the J1 byte. From that marker it counts columns and rows, finds the nine overhead bytes and latches each one. The latched bytes are held in a bank that can be read at any time, and each new byte is also announced on a single strobe port.

Parity is checked with BIP-8 over each whole SPE. The remote error indication in G1 is decoded. Both kinds of error go into saturating counters, and one control input selects whether a count is per errored bit or per errored frame. The block filters the signal label in C2 and the remote defect field in G1 over a number of frames. From the filtered values it raises the unequipped, label mismatch, label unstable, payload defect, remote defect and enhanced remote defect indications.

A number of B3 error-rate monitors run side by side, two by default. Each one has its own window length, its own set threshold and its own clear threshold.

Top module: `pom_top`

## Requirements
- R1: Counting from the byte marked by spJ1 as column 0, row 0, with COLS bytes per row, the column-0 byte of row r (r = 0..8) is an overhead byte. The slots are J1=0, B3=1, C2=2, G1=3, F2=4, H4=5, Z3=6, Z4=7, Z5=8. One cycle after such a byte is accepted, ohStrobe is high, ohSlot = r and ohByte holds the byte, and ohBank[r] holds it from then on.
- R2: BIP-8 is the XOR of every accepted byte from one J1 up to the byte before the next J1. It is compared with the B3 byte of the following SPE, and no comparison is made for the first SPE after reset. In bit mode (blockMode = 0), b3ErrCnt grows by the number of mismatched bits.
- R3: In block mode (blockMode = 1), b3ErrCnt grows by one for each SPE with any mismatched bit.
- R4: The REI field is G1[7:4]. Values 1 to 8 add that value to reiErrCnt in bit mode and add 1 in block mode. Values 0 and 9 to 15 add nothing.
- R5: b3ErrCnt and reiErrCnt hold at all-ones rather than wrapping.
- R6: A C2 value becomes the accepted label after PERSIST consecutive SPEs carry it. uneqAlarm is high while the accepted label is 00h.
- R7: pdiAlarm is high while the accepted label lies in E1h..FCh. plmAlarm is high while the accepted label differs from expLabel, is neither 00h nor 01h, and is outside E1h..FCh.
- R8: pluAlarm rises once C2 has changed from one SPE to the next PERSIST times since the last acceptance. It falls when a label is accepted.
- R9: rdiAlarm takes the value of G1[3] once that bit has held the same value for PERSIST consecutive SPEs.
- R10: erdiCode takes G1[3:1] once that field has held the same value for PERSIST consecutive SPEs. erdiValid goes high at the first such acceptance.
- R11: Each rate monitor k adds the B3 error amount of every checked SPE to a window sum, using the selected mode. rmAlarm[k] sets as soon as the sum exceeds rmSetThr[k]. When rmWindow[k] checked SPEs have been seen, the window ends, rmAlarm[k] clears if the final sum is below rmClrThr[k], and the sum restarts.
- R12: The rate monitors are independent, and each uses only its own window and thresholds.
- R13: Bytes accepted before the first J1 after reset produce no overhead strobe.
- R14: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| spByte | input | 8 | SPE byte |
| spValid | input | 1 | spByte carries a byte this cycle |
| spJ1 | input | 1 | This byte is J1 (start of SPE) |
| blockMode | input | 1 | 0: bit counting, 1: block counting |
| expLabel | input | 8 | Expected C2 label |
| rmWindow | input | NUM_MON x WIN_W | Window length per rate monitor, in checked SPEs |
| rmSetThr | input | NUM_MON x CNT_W | Set threshold per rate monitor |
| rmClrThr | input | NUM_MON x CNT_W | Clear threshold per rate monitor |
| ohByte | output | 8 | Latest overhead byte |
| ohSlot | output | 4 | Slot of the latest overhead byte |
| ohStrobe | output | 1 | New overhead byte presented |
| ohBank | output | 9 x 8 | Latched overhead bytes, indexed by slot |
| b3ErrCnt | output | CNT_W | Accumulated B3 errors |
| reiErrCnt | output | CNT_W | Accumulated REI errors |
| rmAlarm | output | NUM_MON | Rate monitor alarms |
| uneqAlarm | output | 1 | Unequipped |
| plmAlarm | output | 1 | Label mismatch |
| pluAlarm | output | 1 | Label unstable |
| pdiAlarm | output | 1 | Payload defect indication |
| rdiAlarm | output | 1 | Remote defect |
| erdiCode | output | 3 | Accepted enhanced remote defect code |
| erdiValid | output | 1 | erdiCode has been accepted |

## Verification
The bench builds the block with COLS = 4, so an SPE lasts 36 bytes instead of 783 and dozens of frames fit in a short run. PERSIST = 3 brings the filter thresholds, and both edges of every acceptance, within a few frames. CNT_W = 8 makes the error counters reach all-ones in about thirty errored frames, so saturation can be checked. WIN_W = 4 allows short windows, so both rate monitors can be driven through set, hold and clear with different window lengths in the same run.

// File: rtl/pom_pkg.sv
package pom_pkg;
  localparam int POH_ROWS = 9;
  localparam int SLOT_W = 4;

  localparam logic [SLOT_W-1:0] SLOT_J1 = 4'd0;
  localparam logic [SLOT_W-1:0] SLOT_B3 = 4'd1;
  localparam logic [SLOT_W-1:0] SLOT_C2 = 4'd2;
  localparam logic [SLOT_W-1:0] SLOT_G1 = 4'd3;

  // strobes from framing control to the datapath
  typedef struct packed {
    logic              live;   // byte belongs to a located SPE
    logic              start;  // byte is J1
    logic              poh;    // byte is an overhead byte
    logic [SLOT_W-1:0] slot;   // overhead slot (row)
  } pom_strobe_t;

  function automatic logic [3:0] pop8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/pom_ctrl.sv
module pom_ctrl
  import pom_pkg::*;
#(
  parameter int COLS = 87
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spValid,
  input  logic        spJ1,
  output pom_strobe_t strb
);
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [COL_W-1:0]  colNext, curCol;
  logic [SLOT_W-1:0] rowNext, curRow;
  logic              locked;

  always_comb begin
    curCol     = spJ1 ? '0 : colNext;
    curRow     = spJ1 ? '0 : rowNext;
    strb.start = spValid && spJ1;
    strb.live  = spValid && (spJ1 || locked);
    strb.poh   = strb.live && (curCol == '0) && (curRow < SLOT_W'(POH_ROWS));
    strb.slot  = curRow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colNext <= '0;
      rowNext <= '0;
      locked  <= 1'b0;
    end else if (strb.live) begin
      locked <= 1'b1;
      if (curCol == COL_LAST) begin
        colNext <= '0;
        rowNext <= (curRow == '1) ? curRow : curRow + 1'b1;
      end else begin
        colNext <= curCol + 1'b1;
        rowNext <= curRow;
      end
    end
  end

  // R13
  no_early_poh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !spJ1) |-> !strb.poh);
endmodule

// File: rtl/pom_persist.sv
module pom_persist #(
  parameter int W = 8,
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc,
  output logic         known,
  output logic         diff,
  output logic         accept
);
  localparam int RUN_W = $clog2(N + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(N);

  logic [W-1:0]     last;
  logic             haveLast;
  logic [RUN_W-1:0] run, runNew;

  always_comb begin
    diff = load && haveLast && (din != last);
    if (haveLast && (din == last))
      runNew = (run >= RUN_MAX) ? RUN_MAX : run + 1'b1;
    else
      runNew = RUN_W'(1);
    accept = load && (runNew >= RUN_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      last     <= '0;
      haveLast <= 1'b0;
      run      <= '0;
      acc      <= '0;
      known    <= 1'b0;
    end else if (load) begin
      last     <= din;
      haveLast <= 1'b1;
      run      <= runNew;
      if (accept) begin
        acc   <= din;
        known <= 1'b1;
      end
    end
  end

  // R10
  known_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    known |=> known);
endmodule

// File: rtl/pom_ratemon.sv
module pom_ratemon #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evt,
  input  logic [3:0]       amt,
  input  logic [WIN_W-1:0] winLen,
  input  logic [CNT_W-1:0] setThr,
  input  logic [CNT_W-1:0] clrThr,
  output logic             alarm
);
  logic [WIN_W-1:0] frmCnt;
  logic [CNT_W-1:0] errCnt, sum;
  logic [CNT_W:0]   sumW;
  logic [WIN_W:0]   frmNext;
  logic             winEnd;

  always_comb begin
    sumW    = {1'b0, errCnt} + (CNT_W + 1)'(amt);
    sum     = sumW[CNT_W] ? '1 : sumW[CNT_W-1:0];
    frmNext = {1'b0, frmCnt} + 1'b1;
    winEnd  = frmNext >= {1'b0, winLen};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmCnt <= '0;
      errCnt <= '0;
      alarm  <= 1'b0;
    end else if (evt) begin
      if (winEnd) begin
        frmCnt <= '0;
        errCnt <= '0;
      end else begin
        frmCnt <= frmNext[WIN_W-1:0];
        errCnt <= sum;
      end
      if (sum > setThr)
        alarm <= 1'b1;
      else if (winEnd && (sum < clrThr))
        alarm <= 1'b0;
    end
  end

  // R11
  alarm_rise_on_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarm) |-> $past(evt));
  // R11
  alarm_fall_on_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarm) |-> $past(evt));
endmodule

// File: rtl/pom_datapath.sv
module pom_datapath
  import pom_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PERSIST = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pom_strobe_t                   strb,
  input  logic [7:0]                    spByte,
  input  logic                          blockMode,
  input  logic [7:0]                    expLabel,
  output logic [7:0]                    ohByte,
  output logic [SLOT_W-1:0]             ohSlot,
  output logic                          ohStrobe,
  output logic [POH_ROWS-1:0][7:0]      ohBank,
  output logic [CNT_W-1:0]              b3ErrCnt,
  output logic [CNT_W-1:0]              reiErrCnt,
  output logic                          b3Evt,
  output logic [3:0]                    b3Amt,
  output logic                          uneqAlarm,
  output logic                          plmAlarm,
  output logic                          pluAlarm,
  output logic                          pdiAlarm,
  output logic                          rdiAlarm,
  output logic [2:0]                    erdiCode,
  output logic                          erdiValid
);
  localparam int RUN_W = $clog2(PERSIST + 1);

  function automatic logic [CNT_W-1:0] satAdd(input logic [CNT_W-1:0] c, input logic [3:0] a);
    logic [CNT_W:0] s;
    s = {1'b0, c} + (CNT_W + 1)'(a);
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  // ---------------- overhead capture ----------------
  for (genvar s = 0; s < POH_ROWS; s++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) ohBank[s] <= '0;
      else if (strb.poh && (strb.slot == SLOT_W'(s))) ohBank[s] <= spByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ohByte   <= '0;
      ohSlot   <= '0;
      ohStrobe <= 1'b0;
    end else begin
      ohStrobe <= strb.poh;
      if (strb.poh) begin
        ohByte <= spByte;
        ohSlot <= strb.slot;
      end
    end
  end

  // ---------------- BIP-8 ----------------
  logic [7:0] bipAcc, bipPrev;
  logic       seenFrame, bipHave;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bipAcc    <= '0;
      bipPrev   <= '0;
      seenFrame <= 1'b0;
      bipHave   <= 1'b0;
    end else if (strb.start) begin
      bipPrev   <= bipAcc;
      bipHave   <= seenFrame;
      bipAcc    <= spByte;
      seenFrame <= 1'b1;
    end else if (strb.live) begin
      bipAcc <= bipAcc ^ spByte;
    end
  end

  logic       isB3, isC2, isG1, reiOk;
  logic [7:0] mism;
  logic [3:0] b3Add, reiAdd, reiVal;

  always_comb begin
    isB3   = strb.poh && (strb.slot == SLOT_B3) && bipHave;
    isC2   = strb.poh && (strb.slot == SLOT_C2);
    isG1   = strb.poh && (strb.slot == SLOT_G1);
    mism   = bipPrev ^ spByte;
    b3Add  = blockMode ? {3'b0, |mism} : pop8(mism);
    reiVal = spByte[7:4];
    reiOk  = (reiVal >= 4'd1) && (reiVal <= 4'd8);
    if (!reiOk)        reiAdd = 4'd0;
    else if (blockMode) reiAdd = 4'd1;
    else               reiAdd = reiVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      b3ErrCnt  <= '0;
      reiErrCnt <= '0;
      b3Evt     <= 1'b0;
      b3Amt     <= '0;
    end else begin
      b3Evt <= isB3;
      if (isB3) begin
        b3Amt    <= b3Add;
        b3ErrCnt <= satAdd(b3ErrCnt, b3Add);
      end
      if (isG1) reiErrCnt <= satAdd(reiErrCnt, reiAdd);
    end
  end

  // ---------------- label and remote defect filters ----------------
  logic [7:0] c2Acc;
  logic       c2Known, c2Diff, c2Accept;
  logic [0:0] rdiAcc;
  logic       rdiKnown, rdiDiff, rdiAccept;
  logic       erdiDiff, erdiAccept;

  pom_persist #(.W(8), .N(PERSIST)) c2Filt_i (
    .clk(clk), .rstN(rstN), .load(isC2), .din(spByte),
    .acc(c2Acc), .known(c2Known), .diff(c2Diff), .accept(c2Accept));

  pom_persist #(.W(1), .N(PERSIST)) rdiFilt_i (
    .clk(clk), .rstN(rstN), .load(isG1), .din(spByte[3]),
    .acc(rdiAcc), .known(rdiKnown), .diff(rdiDiff), .accept(rdiAccept));

  pom_persist #(.W(3), .N(PERSIST)) erdiFilt_i (
    .clk(clk), .rstN(rstN), .load(isG1), .din(spByte[3:1]),
    .acc(erdiCode), .known(erdiValid), .diff(erdiDiff), .accept(erdiAccept));

  logic [RUN_W-1:0] chgCnt, chgNext;

  always_comb chgNext = (chgCnt >= RUN_W'(PERSIST)) ? chgCnt : chgCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chgCnt   <= '0;
      pluAlarm <= 1'b0;
    end else if (c2Accept) begin
      chgCnt   <= '0;
      pluAlarm <= 1'b0;
    end else if (c2Diff) begin
      chgCnt <= chgNext;
      if (chgNext >= RUN_W'(PERSIST)) pluAlarm <= 1'b1;
    end
  end

  always_comb begin
    uneqAlarm = c2Known && (c2Acc == 8'h00);
    pdiAlarm  = c2Known && (c2Acc >= 8'hE1) && (c2Acc <= 8'hFC);
    plmAlarm  = c2Known && (c2Acc != expLabel) && (c2Acc != 8'h00) &&
                (c2Acc != 8'h01) && !pdiAlarm;
    rdiAlarm  = rdiKnown && rdiAcc[0];
  end

  // ---------------- checks ----------------
  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ohStrobe |-> (ohSlot < SLOT_W'(POH_ROWS)));
  // R2
  b3_only_on_b3_chk: assert property (@(posedge clk) disable iff (!rstN)
    (b3ErrCnt != $past(b3ErrCnt)) |-> b3Evt);
  // R5
  b3_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (b3ErrCnt >= $past(b3ErrCnt)));
  // R3
  b3_block_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockMode |=> ((b3ErrCnt == $past(b3ErrCnt)) || (b3ErrCnt == $past(b3ErrCnt) + 1'b1)));
  // R4
  rei_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((reiErrCnt >= $past(reiErrCnt)) &&
              ({1'b0, reiErrCnt} <= {1'b0, $past(reiErrCnt)} + (CNT_W + 1)'(8))));
  // R7
  label_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    plmAlarm |-> (!uneqAlarm && !pdiAlarm));
endmodule

// File: rtl/pom_top.sv
module pom_top
  import pom_pkg::*;
#(
  parameter int COLS    = 87,
  parameter int PERSIST = 5,
  parameter int CNT_W   = 16,
  parameter int WIN_W   = 12,
  parameter int NUM_MON = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [7:0]                        spByte,
  input  logic                              spValid,
  input  logic                              spJ1,
  input  logic                              blockMode,
  input  logic [7:0]                        expLabel,
  input  logic [NUM_MON-1:0][WIN_W-1:0]     rmWindow,
  input  logic [NUM_MON-1:0][CNT_W-1:0]     rmSetThr,
  input  logic [NUM_MON-1:0][CNT_W-1:0]     rmClrThr,
  output logic [7:0]                        ohByte,
  output logic [SLOT_W-1:0]                 ohSlot,
  output logic                              ohStrobe,
  output logic [POH_ROWS-1:0][7:0]          ohBank,
  output logic [CNT_W-1:0]                  b3ErrCnt,
  output logic [CNT_W-1:0]                  reiErrCnt,
  output logic [NUM_MON-1:0]                rmAlarm,
  output logic                              uneqAlarm,
  output logic                              plmAlarm,
  output logic                              pluAlarm,
  output logic                              pdiAlarm,
  output logic                              rdiAlarm,
  output logic [2:0]                        erdiCode,
  output logic                              erdiValid
);
  pom_strobe_t strb;
  logic        b3Evt;
  logic [3:0]  b3Amt;

  pom_ctrl #(.COLS(COLS)) ctrl_i (
    .clk(clk), .rstN(rstN), .spValid(spValid), .spJ1(spJ1), .strb(strb));

  pom_datapath #(.CNT_W(CNT_W), .PERSIST(PERSIST)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .spByte(spByte),
    .blockMode(blockMode), .expLabel(expLabel),
    .ohByte(ohByte), .ohSlot(ohSlot), .ohStrobe(ohStrobe), .ohBank(ohBank),
    .b3ErrCnt(b3ErrCnt), .reiErrCnt(reiErrCnt), .b3Evt(b3Evt), .b3Amt(b3Amt),
    .uneqAlarm(uneqAlarm), .plmAlarm(plmAlarm), .pluAlarm(pluAlarm),
    .pdiAlarm(pdiAlarm), .rdiAlarm(rdiAlarm), .erdiCode(erdiCode),
    .erdiValid(erdiValid));

  for (genvar k = 0; k < NUM_MON; k++) begin : g_mon
    pom_ratemon #(.CNT_W(CNT_W), .WIN_W(WIN_W)) mon_i (
      .clk(clk), .rstN(rstN), .evt(b3Evt), .amt(b3Amt),
      .winLen(rmWindow[k]), .setThr(rmSetThr[k]), .clrThr(rmClrThr[k]),
      .alarm(rmAlarm[k]));
  end
endmodule

// File: tb/pom_top_tb_top.sv
module pom_top_tb_top;
  localparam int COLS = 4;
  localparam int PERSIST = 3;
  localparam int CNT_W = 8;
  localparam int WIN_W = 4;
  localparam int NUM_MON = 2;
  localparam int FRAME = COLS * 9;

  // {mode, errMask, rei, expB3Delta(4), expReiDelta(4)}
  localparam logic [31:0] VEC [8] = '{
    32'h00_00_00_00, 32'h00_01_03_13, 32'h00_FF_08_88, 32'h00_0F_09_40,
    32'h01_F0_08_11, 32'h01_00_0F_00, 32'h01_81_01_11, 32'h00_3C_00_40};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] spByte = '0;
  logic spValid = 1'b0, spJ1 = 1'b0, blockMode = 1'b0;
  logic [7:0] expLabel = 8'h04;
  logic [NUM_MON-1:0][WIN_W-1:0] rmWindow = '0;
  logic [NUM_MON-1:0][CNT_W-1:0] rmSetThr = '1, rmClrThr = '0;
  logic [7:0] ohByte;
  logic [3:0] ohSlot;
  logic ohStrobe;
  logic [8:0][7:0] ohBank;
  logic [CNT_W-1:0] b3ErrCnt, reiErrCnt;
  logic [NUM_MON-1:0] rmAlarm;
  logic uneqAlarm, plmAlarm, pluAlarm, pdiAlarm, rdiAlarm, erdiValid;
  logic [2:0] erdiCode;

  int nChk = 0, nFail = 0, frameNo = 0, strobeCnt = 0;
  logic [7:0] prevPar = '0;
  logic firstFrame = 1'b1;
  logic [7:0] sentPoh [9];
  logic [3:0] lastSlot = '0;
  logic [7:0] lastByte = '0;

  always #5 clk = ~clk;

  pom_top #(.COLS(COLS), .PERSIST(PERSIST), .CNT_W(CNT_W), .WIN_W(WIN_W),
            .NUM_MON(NUM_MON)) dut_i (
    .clk(clk), .rstN(rstN), .spByte(spByte), .spValid(spValid), .spJ1(spJ1),
    .blockMode(blockMode), .expLabel(expLabel), .rmWindow(rmWindow),
    .rmSetThr(rmSetThr), .rmClrThr(rmClrThr), .ohByte(ohByte), .ohSlot(ohSlot),
    .ohStrobe(ohStrobe), .ohBank(ohBank), .b3ErrCnt(b3ErrCnt),
    .reiErrCnt(reiErrCnt), .rmAlarm(rmAlarm), .uneqAlarm(uneqAlarm),
    .plmAlarm(plmAlarm), .pluAlarm(pluAlarm), .pdiAlarm(pdiAlarm),
    .rdiAlarm(rdiAlarm), .erdiCode(erdiCode), .erdiValid(erdiValid));

  always @(negedge clk) if (ohStrobe) begin
    strobeCnt++;
    lastSlot = ohSlot;
    lastByte = ohByte;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    spValid = 1'b0;
    spJ1 = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    firstFrame = 1'b1;
    strobeCnt = 0;
  endtask

  task automatic sendFrame(input logic [7:0] errMask, input logic [7:0] c2v, input logic [7:0] g1v);
    logic [7:0] par, b;
    sentPoh[0] = 8'h6A;
    sentPoh[1] = firstFrame ? 8'h5A : (prevPar ^ errMask);
    sentPoh[2] = c2v;
    sentPoh[3] = g1v;
    for (int s = 4; s < 9; s++) sentPoh[s] = 8'(8'h30 + s * 5);
    par = '0;
    for (int i = 0; i < FRAME; i++) begin
      if ((i % COLS) == 0) b = sentPoh[i / COLS];
      else b = 8'(frameNo * 29 + i * 13 + 7);
      par = par ^ b;
      @(negedge clk);
      spByte = b;
      spValid = 1'b1;
      spJ1 = (i == 0);
    end
    @(negedge clk);
    spValid = 1'b0;
    spJ1 = 1'b0;
    @(negedge clk);
    prevPar = par;
    firstFrame = 1'b0;
    frameNo++;
  endtask

  // bit-mode frame with a given number of B3 errors (low bits flipped)
  task automatic errFrame(input int nErr);
    sendFrame(8'((1 << nErr) - 1), 8'h04, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] b0, r0;
    doReset();
    // R14: reset state
    chk("R14 counters", {b3ErrCnt, reiErrCnt}, 0);
    chk("R14 alarms", {rmAlarm, uneqAlarm, plmAlarm, pluAlarm, pdiAlarm, rdiAlarm, erdiValid, erdiCode, ohStrobe}, 0);
    chk("R14 bank", ohBank, 0);

    // R13: bytes before any J1
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      spByte = 8'h00;
      spValid = 1'b1;
    end
    @(negedge clk);
    spValid = 1'b0;
    @(negedge clk);
    chk("R13 no strobe before J1", strobeCnt, 0);

    // R1 / R2: first frame, deliberately wrong B3, not checked
    blockMode = 1'b0;
    sendFrame(8'h00, 8'h04, 8'h00);
    chk("R1 strobe count", strobeCnt, 9);
    chk("R1 last slot", lastSlot, 8);
    chk("R1 last byte", lastByte, sentPoh[8]);
    for (int s = 0; s < 9; s++) chk("R1 bank slot", ohBank[s], sentPoh[s]);
    chk("R2 first frame unchecked", b3ErrCnt, 0);

    // vector table: R2 R3 R4
    for (int v = 0; v < 8; v++) begin
      b0 = b3ErrCnt;
      r0 = reiErrCnt;
      blockMode = VEC[v][24];
      sendFrame(VEC[v][23:16], 8'h04, {VEC[v][11:8], 4'h0});
      chk(VEC[v][24] ? "R3 block b3" : "R2 bit b3", b3ErrCnt, 32'(b0) + 32'(VEC[v][7:4]));
      chk("R4 rei", reiErrCnt, 32'(r0) + 32'(VEC[v][3:0]));
    end

    // R6 R7 R8: label filtering
    doReset();
    blockMode = 1'b0;
    sendFrame(8'h00, 8'h00, 8'h00);
    sendFrame(8'h00, 8'h00, 8'h00);
    chk("R6 uneq before persist", uneqAlarm, 0);
    sendFrame(8'h00, 8'h00, 8'h00);
    chk("R6 uneq after persist", uneqAlarm, 1);
    chk("R9 rdi clear", rdiAlarm, 0);
    chk("R10 erdi accepted zero", {erdiValid, erdiCode}, 4'b1000);
    repeat (3) sendFrame(8'h00, 8'h07, 8'h00);
    chk("R7 plm on mismatch", {plmAlarm, uneqAlarm, pdiAlarm}, 3'b100);
    repeat (3) sendFrame(8'h00, 8'hE5, 8'h00);
    chk("R7 pdi range", {plmAlarm, pdiAlarm}, 2'b01);
    repeat (3) sendFrame(8'h00, 8'h01, 8'h00);
    chk("R7 equipped non-specific", {plmAlarm, pdiAlarm, uneqAlarm}, 0);
    sendFrame(8'h00, 8'h10, 8'h00);
    sendFrame(8'h00, 8'h11, 8'h00);
    chk("R8 plu before limit", pluAlarm, 0);
    sendFrame(8'h00, 8'h10, 8'h00);
    chk("R8 plu set", pluAlarm, 1);
    repeat (2) sendFrame(8'h00, 8'h04, 8'h00);
    chk("R8 plu held", pluAlarm, 1);
    sendFrame(8'h00, 8'h04, 8'h00);
    chk("R8 plu cleared", {pluAlarm, plmAlarm}, 0);

    // R9 R10: remote defect
    repeat (2) sendFrame(8'h00, 8'h04, 8'h08);
    chk("R9 rdi before persist", rdiAlarm, 0);
    sendFrame(8'h00, 8'h04, 8'h08);
    chk("R9 rdi set", rdiAlarm, 1);
    chk("R10 erdi code 4", erdiCode, 4);
    repeat (3) sendFrame(8'h00, 8'h04, 8'h0A);
    chk("R10 erdi code 5", erdiCode, 5);
    repeat (2) sendFrame(8'h00, 8'h04, 8'h00);
    chk("R9 rdi held", rdiAlarm, 1);
    sendFrame(8'h00, 8'h04, 8'h00);
    chk("R9 rdi cleared", rdiAlarm, 0);

    // R11 R12: rate monitors
    rmWindow[0] = 4'd4; rmSetThr[0] = 8'd5;  rmClrThr[0] = 8'd2;
    rmWindow[1] = 4'd2; rmSetThr[1] = 8'd10; rmClrThr[1] = 8'd1;
    doReset();
    blockMode = 1'b0;
    errFrame(0);
    errFrame(3);
    chk("R11 m0 below set", rmAlarm[0], 0);
    errFrame(3);
    chk("R11 m0 set", rmAlarm, 2'b01);
    errFrame(0);
    errFrame(0);
    chk("R11 m0 held at window end", rmAlarm, 2'b01);
    errFrame(8);
    chk("R12 m1 below own set", rmAlarm[1], 0);
    errFrame(8);
    chk("R12 m1 set", rmAlarm, 2'b11);
    errFrame(0);
    chk("R12 m1 mid window", rmAlarm[1], 1);
    errFrame(0);
    chk("R12 m1 cleared", rmAlarm, 2'b01);
    repeat (3) errFrame(0);
    chk("R11 m0 held before end", rmAlarm[0], 1);
    errFrame(0);
    chk("R11 m0 cleared", rmAlarm[0], 0);

    // R5: saturation
    doReset();
    blockMode = 1'b0;
    repeat (34) sendFrame(8'hFF, 8'h04, 8'h80);
    chk("R5 b3 saturates", b3ErrCnt, 8'hFF);
    chk("R5 rei saturates", reiErrCnt, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule